// File: doc/BRIEF.md
# Glitch-Free Bank Clock Output Gate

This block sits between four free-running bank clocks and the output pins. It stops and restarts those clocks without producing shortened pulses. The controls are an active-low output enable, a three-level test control and a three-level polarity control. Each bank clock arrives as a level sampled in the block's clock domain. Each bank drives a parameterised number of identical output copies. The output enable is asynchronous and passes through a synchroniser. A bank may change between running and held only while its input sits at that bank's idle level. As a result, every pulse that reaches an output has the full width it had at the input.

The second bank is the feedback bank and keeps running when the output enable goes inactive. The fourth bank can be set to its inverted mode. In that mode its idle level follows the polarity control. In test mode, a bank's select code doubles as a per-bank disable. A four-bit status output shows which banks are currently held.

Three-level inputs use a 2-bit code: 2'b00 LOW, 2'b01 MID, 2'b10 HIGH. The code 2'b11 means a floating pin and is treated as MID. Each bank has a 4-bit select field on `sel_i[4b+3:4b]`, where b = 0..3 for banks 1..4. Its upper pair is the second digit and its lower pair is the first digit. The code LL is 4'b0000 and HH is 4'b1010.

Top module: `clk_out_gater`

## Requirements
- R1: While `rst_n` is low, `held_o` is 4'b1111 and every `q_o` bit is 0. After release, all banks remain held until the enable synchroniser has taken SYNC_STAGES (2) samples.
- R2: `oe_n_i` passes through a SYNC_STAGES-flop synchroniser before it affects any hold decision.
- R3: With `oe_n_i` high (inactive) and test not MID, banks 1, 3 and 4 become held and drive their idle level on all their copies.
- R4: Outside test mode, bank 2 (index 1) is never held because of `oe_n_i`.
- R5: A bank enters or leaves the held state only in a cycle where its input level equals its idle level. Every high pulse of a bank whose idle level is LOW therefore has the same width at the output as at the input.
- R6: The idle level is LOW, except for bank 4 in inverted mode (select 4'b1010). There it is HIGH when the polarity input is MID or HIGH, and LOW when the polarity input is LOW.
- R7: With test MID and `oe_n_i` high, every bank whose select is 4'b0000 is held, bank 2 included. Banks with any other select keep running.
- R8: With test MID (2'b01 or 2'b11) and `oe_n_i` low, no bank is held after the synchroniser has filled.
- R9: A running bank drives its input level on its outputs one clock later. `held_o[b]` is 1 exactly while bank b is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_n_i | input | 1 | Active-low output enable, asynchronous |
| test_i | input | 2 | Three-level test control |
| pol_i | input | 2 | Three-level edge polarity control |
| sel_i | input | 16 | Per-bank select codes, 4 bits per bank |
| bank_clk_i | input | 4 | Free-running bank clock levels |
| q_o | output | 8 | Gated outputs, OUTS_PER_BANK copies per bank |
| held_o | output | 4 | Per-bank held status |

## Verification
The bench uses the default build: four banks, two copies per bank, a two-stage synchroniser, bank 2 free-running and bank 4 able to invert. Each bank toggles with a different half period (2 to 5 cycles). Enable changes therefore land at every phase of every bank, so deferred holds and deferred restarts are both exercised. The two-stage depth keeps the enable latency short enough that a pseudo-random walk over enable, test, polarity and select values crosses many hold and release decisions. A pulse-width monitor on the banks with a LOW idle level catches any shortened pulse.

// File: rtl/gclk_pkg.sv
package gclk_pkg;

  typedef enum logic [1:0] {
    TL_LOW   = 2'b00,
    TL_MID   = 2'b01,
    TL_HIGH  = 2'b10,
    TL_FLOAT = 2'b11
  } tri_lvl_e;

  localparam int SEL_W = 4;

  function automatic logic tl_is_low(input logic [1:0] v);
    return v == TL_LOW;
  endfunction

  function automatic logic tl_is_mid(input logic [1:0] v);
    return (v == TL_MID) || (v == TL_FLOAT);
  endfunction

  function automatic logic sel_is_ll(input logic [SEL_W-1:0] s);
    return s == {TL_LOW, TL_LOW};
  endfunction

  function automatic logic sel_is_hh(input logic [SEL_W-1:0] s);
    return s == {TL_HIGH, TL_HIGH};
  endfunction

endpackage

// File: rtl/gclk_oe_sync.sv
module gclk_oe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_n_i,
  output logic oe_off_o,
  output logic ready_o
);
  localparam int CW = $clog2(STAGES + 1);
  localparam logic [CW-1:0] FULL = CW'(STAGES);

  logic [STAGES-1:0] chain_q, chain_n;
  logic [CW-1:0]     fill_q, fill_n;
  logic              fill_en;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], oe_n_i};
    fill_en = (fill_q != FULL);
    fill_n  = fill_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      fill_q  <= '0;
    end else begin
      chain_q <= chain_n;
      if (fill_en) fill_q <= fill_n;
    end
  end

  assign oe_off_o = chain_q[STAGES-1];
  assign ready_o  = (fill_q == FULL);

  // R1
  ready_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> ready_o);

  // R2
  sync_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q != '0) |-> chain_q[0] == $past(oe_n_i));

endmodule

// File: rtl/gclk_bank_gate.sv
module gclk_bank_gate
  import gclk_pkg::*;
#(
  parameter int OPB     = 2,
  parameter bit INV_CAP = 1'b0,
  parameter bit IS_FREE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [1:0]       pol_i,
  input  logic [1:0]       test_i,
  input  logic             oe_off_i,
  input  logic             ready_i,
  output logic [OPB-1:0]   q_o,
  output logic             held_o
);
  logic inv_mode, idle_w, test_mode, want_hold, at_idle;
  logic held_q, held_n;
  logic q_q, q_n;

  always_comb begin
    inv_mode  = INV_CAP && sel_is_hh(sel_i);
    idle_w    = inv_mode && !tl_is_low(pol_i);
    test_mode = tl_is_mid(test_i);
    if (test_mode) want_hold = !ready_i || (oe_off_i && sel_is_ll(sel_i));
    else           want_hold = !ready_i || (oe_off_i && !IS_FREE);
    at_idle   = (lvl_i == idle_w);
    held_n    = at_idle ? want_hold : held_q;
    q_n       = held_n ? idle_w : lvl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b1;
      q_q    <= 1'b0;
    end else begin
      held_q <= held_n;
      q_q    <= q_n;
    end
  end

  assign q_o    = {OPB{q_q}};
  assign held_o = held_q;

  // R5
  no_runt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_i && (held_q != $past(held_q)) |-> $past(lvl_i) == $past(idle_w));

  // R6
  held_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_i && held_q |-> q_q == $past(idle_w));

  // R7
  ll_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_i && tl_is_mid(test_i) && oe_off_i && sel_is_ll(sel_i) && held_q |=> held_q);

  // R4
  free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    IS_FREE && ready_i && !tl_is_mid(test_i) && !held_q |=> !held_q);

endmodule

// File: rtl/clk_out_gater.sv
module clk_out_gater
  import gclk_pkg::*;
#(
  parameter int NB            = 4,
  parameter int OUTS_PER_BANK = 2,
  parameter int SYNC_STAGES   = 2,
  parameter int FREE_BANK     = 1,
  parameter int INV_BANK      = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    oe_n_i,
  input  logic [1:0]              test_i,
  input  logic [1:0]              pol_i,
  input  logic [NB*SEL_W-1:0]     sel_i,
  input  logic [NB-1:0]           bank_clk_i,
  output logic [NB*OUTS_PER_BANK-1:0] q_o,
  output logic [NB-1:0]           held_o
);
  logic oe_off, ready;

  gclk_oe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .oe_n_i   (oe_n_i),
    .oe_off_o (oe_off),
    .ready_o  (ready)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    gclk_bank_gate #(
      .OPB     (OUTS_PER_BANK),
      .INV_CAP (b == INV_BANK),
      .IS_FREE (b == FREE_BANK)
    ) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl_i    (bank_clk_i[b]),
      .sel_i    (sel_i[b*SEL_W +: SEL_W]),
      .pol_i    (pol_i),
      .test_i   (test_i),
      .oe_off_i (oe_off),
      .ready_i  (ready),
      .q_o      (q_o[b*OUTS_PER_BANK +: OUTS_PER_BANK]),
      .held_o   (held_o[b])
    );
  end

  // R1
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> held_o == '1);

  // R8
  test_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready && tl_is_mid(test_i) && !oe_off && (held_o == '0) |=> held_o == '0);

endmodule

// File: tb/clk_out_gater_bench.sv
module clk_out_gater_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        oe_n = 1'b0;
  logic [1:0]  test = 2'b00;
  logic [1:0]  pol = 2'b10;
  logic [15:0] sel = 16'h5555;
  logic [3:0]  lvl = 4'b0000;
  logic [7:0]  q_o;
  logic [3:0]  held_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit cmp_en = 1'b0;
  string tag = "R2";

  always #10 clk = ~clk;

  clk_out_gater u_clk_out_gater (
    .clk(clk), .rst_n(rst_n), .oe_n_i(oe_n), .test_i(test), .pol_i(pol),
    .sel_i(sel), .bank_clk_i(lvl), .q_o(q_o), .held_o(held_o)
  );

  task automatic chk(input string t, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", t, act, exp);
    end
  endtask

  // behavioural reference model
  int s0, s1, fillc;
  logic [3:0] m_held;
  logic [7:0] m_q;

  function automatic bit mid(input logic [1:0] v); return v == 2'b01 || v == 2'b11; endfunction
  function automatic int idle_of(input int b);
    return (b == 3 && sel[15:12] == 4'b1010 && pol != 2'b00) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0 = 1; s1 = 1; fillc = 0; m_held = 4'hF; m_q = 8'h00;
    end else begin
      for (int b = 0; b < 4; b++) begin
        int idl;
        bit want;
        idl = idle_of(b);
        if (mid(test)) want = (fillc < 2) || (s1 == 1 && sel[4*b +: 4] == 4'b0000);
        else           want = (fillc < 2) || (s1 == 1 && b != 1);
        if (int'(lvl[b]) == idl) m_held[b] = want;
        m_q[2*b]   = m_held[b] ? idl[0] : lvl[b];
        m_q[2*b+1] = m_q[2*b];
      end
      s1 = s0; s0 = int'(oe_n);
      if (fillc < 2) fillc++;
    end
  end

  // stimulus clocks: bank b toggles every b+2 cycles
  always @(negedge clk) begin
    cyc++;
    for (int b = 0; b < 4; b++) lvl[b] <= ((cyc / (b + 2)) % 2) == 1;
  end

  // per-cycle comparison and pulse-width monitor (R5)
  int run[3] = '{0, 0, 0};
  always @(negedge clk) begin
    if (cmp_en) begin
      chk(tag, {4'h0, held_o, q_o}, {4'h0, m_held, m_q});
      for (int b = 0; b < 3; b++) begin
        if (q_o[2*b]) run[b]++;
        else begin
          if (run[b] != 0) chk("R5", 16'(run[b]), 16'(b + 2));
          run[b] = 0;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    chk("R1", {12'h0, held_o}, 16'h000F);
    chk("R1", {8'h0, q_o}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {12'h0, held_o}, 16'h000F);
    cmp_en = 1'b1;
    tag = "R9";
    repeat (40) @(negedge clk);
    chk("R9", {12'h0, held_o}, 16'h0000);

    tag = "R3"; oe_n = 1'b1;
    repeat (40) @(negedge clk);
    chk("R3", {12'h0, held_o}, 16'h000D);
    chk("R4", {15'h0, held_o[1]}, 16'h0000);
    chk("R3", {8'h0, q_o & 8'hF3}, 16'h0000);

    tag = "R6"; sel[15:12] = 4'b1010; pol = 2'b10;
    repeat (30) @(negedge clk);
    chk("R6", {14'h0, q_o[7:6]}, 16'h0003);
    pol = 2'b00;
    repeat (30) @(negedge clk);
    chk("R6", {14'h0, q_o[7:6]}, 16'h0000);
    pol = 2'b01;
    repeat (30) @(negedge clk);
    chk("R6", {14'h0, q_o[7:6]}, 16'h0003);

    tag = "R5"; oe_n = 1'b0;
    repeat (30) @(negedge clk);
    chk("R5", {12'h0, held_o}, 16'h0000);

    tag = "R7"; test = 2'b01; sel = 16'h5005; oe_n = 1'b1;
    repeat (30) @(negedge clk);
    chk("R7", {12'h0, held_o}, 16'h0006);

    tag = "R8"; oe_n = 1'b0;
    repeat (30) @(negedge clk);
    chk("R8", {12'h0, held_o}, 16'h0000);
    test = 2'b11; oe_n = 1'b1;
    repeat (30) @(negedge clk);
    chk("R7", {12'h0, held_o}, 16'h0006);
    oe_n = 1'b0;
    repeat (30) @(negedge clk);
    chk("R8", {12'h0, held_o}, 16'h0000);

    tag = "R2"; lf = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      oe_n = lf[0] & lf[3];
      if (lf[5:2] == 4'h0) test = lf[7:6];
      if (lf[9:6] == 4'h1) pol = lf[11:10];
      if (lf[12:9] == 4'h2) begin
        for (int b = 0; b < 4; b++)
          sel[4*b +: 4] = (lf[b*3 +: 2] == 2'd0) ? 4'b0000 :
                          (lf[b*3 +: 2] == 2'd1) ? 4'b1010 : 4'b0101;
      end
    end

    cmp_en = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule